// File: doc/BRIEF.md
# DRAM Read Cycle Sequencer

This block runs read accesses to an asynchronous DRAM over a 16-bit external data bus. A requester presents a byte address, an access size (one half-word or one 32-bit word) and a one-cycle start strobe while the block is idle. Each bus access is a fixed cycle of five clock phases, Q1 to Q5. The row and column addresses share one multiplexed address bus. The block drives the row strobe, the column strobe(s), the write enables (held inactive), the read strobe and the chip select.

A 4-bit page-size setting chooses where the half-word address splits into row and column parts. A mode input chooses between two strobe styles: one shared CAS with a pair of byte write enables, or separate lower and upper CAS lines with one shared write enable. A 32-bit read becomes two back-to-back five-phase cycles, at the base address and then at base+2. The block assembles the two halves into one word and presents it together with a one-clock done pulse.

Top module: `dram_rd_seq`

## Requirements
- R1: After reset, and at once whenever reset is asserted (even mid-access), busy and done are 0 and every active-low strobe (ras_n, cas_n, casl_n, cash_n, we_n, wel_n, weh_n, rd_n, cs_n) is 1.
- R2: A start accepted at a clock edge makes the next cycle Q1, followed by Q2..Q5 one per clock. ras_n, cs_n and rd_n are 1 in Q1 and 0 in Q2 through Q5.
- R3: mem_addr carries the row address in Q2 and Q3 and the column address in Q4 and Q5. The Q1 value carries no meaning.
- R4: The half-word index is req_addr shifted right by one. The column width is 8 + cfg_page bits. The column is the low (8 + cfg_page) bits of the index, and the row is the index shifted right by (8 + cfg_page). Both are zero-extended onto mem_addr.
- R5: With cfg_dualcas = 0, cas_n is 0 in Q4 and Q5 and 1 otherwise, while casl_n and cash_n stay 1. All write enables stay 1 in every phase.
- R6: With cfg_dualcas = 1, casl_n and cash_n are both 0 in Q4 and Q5 and 1 otherwise, while cas_n stays 1.
- R7: Read data is sampled from mem_dq at the clock edge that ends Q5, where the column strobe rises. mem_dq[15:8] is the lower-address byte and mem_dq[15:0] forms one half-word in that order.
- R8: With req_word = 1, a second Q1..Q5 cycle at index+1 follows the first Q5 with no idle cycle. The result holds the first half-word in rdata[31:16] and the second in rdata[15:0]. The index increment may carry into the row.
- R9: With req_word = 0, one cycle runs and rdata = {half-word, 16'h0000}.
- R10: done is 1 for exactly the one cycle after the final Q5, with rdata valid in that cycle. busy is 1 from Q1 through the final Q5.
- R11: A start raised while busy is ignored: the running access completes with its own address, and no further access follows.
- R12: The address, size, page size and mode are captured when the start is accepted. Changing the inputs during an access has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe, taken only when idle |
| req_addr | input | ADDR_W | Byte address of the read |
| req_word | input | 1 | 1 = 32-bit word, 0 = half-word |
| cfg_page | input | 4 | Page-size setting; column width is 8 + value |
| cfg_dualcas | input | 1 | 0 = one CAS with two WE, 1 = two CAS with one WE |
| mem_dq | input | 16 | Upper 16 data lanes from the DRAM |
| mem_addr | output | ADDR_W | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Shared column strobe, active low |
| casl_n | output | 1 | Lower-byte column strobe, active low |
| cash_n | output | 1 | Upper-byte column strobe, active low |
| wel_n | output | 1 | Lower-byte write enable, held high |
| weh_n | output | 1 | Upper-byte write enable, held high |
| we_n | output | 1 | Shared write enable, held high |
| rd_n | output | 1 | Read strobe, active low |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read result |

## Verification
The embedded properties watch the strobe nesting on every cycle. A column strobe is never low without the row strobe, and the split strobes always move as a pair. Each Q1 keeps the row strobe high, the row address holds steady from Q2 into Q3, and done is one cycle long and always follows a column-strobe phase. Only the bench's scenarios can show the row/column split for each page size and a carry across a row boundary. They also show the assembled data order, that a start is ignored while busy, that inputs changed mid-access have no effect, and that a reset in mid-access clears the bus.

// File: rtl/dram_rd_seq.sv
module dram_rd_seq #(
  parameter int ADDR_W  = 25,
  parameter int COL_MIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic [3:0]        cfg_page,
  input  logic              cfg_dualcas,
  input  logic [15:0]       mem_dq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              casl_n,
  output logic              cash_n,
  output logic              wel_n,
  output logic              weh_n,
  output logic              we_n,
  output logic              rd_n,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata
);
  localparam logic [2:0] P_IDLE = 3'd0, P_Q1 = 3'd1, P_Q5 = 3'd5;

  logic [2:0]        phase;
  logic [ADDR_W-1:0] idx_q;
  logic              word_q, second_q, dual_q;
  logic [3:0]        page_q;
  logic [15:0]       hi_q;
  logic [4:0]        col_w;
  logic [ADDR_W-1:0] row_a, col_a;
  logic              act, colph;

  assign col_w = 5'(COL_MIN) + {1'b0, page_q};
  assign row_a = idx_q >> col_w;
  assign col_a = idx_q & ~({ADDR_W{1'b1}} << col_w);

  assign busy  = (phase != P_IDLE);
  assign act   = (phase >= 3'd2);
  assign colph = (phase >= 3'd4);

  assign ras_n  = ~act;
  assign cs_n   = ~act;
  assign rd_n   = ~act;
  assign cas_n  = ~(colph & ~dual_q);
  assign casl_n = ~(colph & dual_q);
  assign cash_n = ~(colph & dual_q);
  assign we_n   = 1'b1;
  assign wel_n  = 1'b1;
  assign weh_n  = 1'b1;
  assign mem_addr = colph ? col_a : (act ? row_a : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      idx_q    <= '0;
      word_q   <= 1'b0;
      second_q <= 1'b0;
      dual_q   <= 1'b0;
      page_q   <= '0;
      hi_q     <= '0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        P_IDLE: if (req_start) begin
          idx_q    <= req_addr >> 1;
          word_q   <= req_word;
          page_q   <= cfg_page;
          dual_q   <= cfg_dualcas;
          second_q <= 1'b0;
          phase    <= P_Q1;
        end
        P_Q5: if (word_q && !second_q) begin
          hi_q     <= mem_dq;
          second_q <= 1'b1;
          idx_q    <= idx_q + ADDR_W'(1);
          phase    <= P_Q1;
        end else begin
          rdata <= second_q ? {hi_q, mem_dq} : {mem_dq, 16'h0000};
          done  <= 1'b1;
          phase <= P_IDLE;
        end
        default: phase <= phase + 3'd1;
      endcase
    end
  end

  a_r5_cas_within_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n || !casl_n) |-> !ras_n);
  a_r6_split_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (casl_n == cash_n) && (cas_n || casl_n));
  a_r2_q1_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ras_n);
  a_r3_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> $stable(mem_addr));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!cas_n || !casl_n));
endmodule

// File: tb/sim_dram_rd_seq.sv
`timescale 1ns/1ps
module sim_dram_rd_seq;
  localparam int AW = 25;
  localparam int NV = 6;
  localparam logic [AW-1:0] VA [NV] = '{25'h0012344, 25'h1ABCDE6, 25'h0000FFE,
                                        25'h1FFFFFE, 25'h0345678, 25'h0F0F0F0};
  localparam logic          VW [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [3:0]    VP [NV] = '{4'd0, 4'd4, 4'd0, 4'd15, 4'd2, 4'd7};
  localparam logic          VD [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 1'b0, req_word = 1'b0, cfg_dualcas = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] cfg_page = '0;
  logic [15:0] mem_dq;
  logic [AW-1:0] mem_addr;
  logic ras_n, cas_n, casl_n, cash_n, wel_n, weh_n, we_n, rd_n, cs_n, busy, done;
  logic [31:0] rdata;
  int total = 0, fails = 0;

  always #4 clk = ~clk;
  assign mem_dq = mem_addr[15:0] ^ 16'hC35A;

  dram_rd_seq u0 (.clk, .rst_n, .req_start, .req_addr, .req_word, .cfg_page,
    .cfg_dualcas, .mem_dq, .mem_addr, .ras_n, .cas_n, .casl_n, .cash_n,
    .wel_n, .weh_n, .we_n, .rd_n, .cs_n, .busy, .done, .rdata);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] row_of(logic [AW-1:0] idx, logic [3:0] pg);
    return idx >> (8 + int'(pg));
  endfunction
  function automatic logic [AW-1:0] col_of(logic [AW-1:0] idx, logic [3:0] pg);
    return idx & ~({AW{1'b1}} << (8 + int'(pg)));
  endfunction

  task automatic chk_idle_bus(input string tag);
    chk({tag, " strobes"}, {ras_n, cas_n, casl_n, cash_n, we_n, wel_n, weh_n, rd_n, cs_n}, 9'h1FF);
    chk({tag, " busy/done"}, {busy, done}, 2'b00);
  endtask

  task automatic chk_phase(input int q, input logic dual, input logic [AW-1:0] idx, input logic [3:0] pg);
    logic a = (q >= 2) ? 1'b0 : 1'b1;
    logic c = (q >= 4) ? 1'b0 : 1'b1;
    chk($sformatf("R2 ras/cs/rd Q%0d", q), {ras_n, cs_n, rd_n}, {a, a, a});
    chk($sformatf("R10 busy Q%0d", q), busy, 1'b1);
    if (q == 2 || q == 3) chk($sformatf("R3 R4 row Q%0d", q), mem_addr, row_of(idx, pg));
    if (q >= 4) chk($sformatf("R3 R4 col Q%0d", q), mem_addr, col_of(idx, pg));
    if (!dual) chk($sformatf("R5 cas single Q%0d", q), {cas_n, casl_n, cash_n}, {c, 1'b1, 1'b1});
    else       chk($sformatf("R6 cas dual Q%0d", q), {cas_n, casl_n, cash_n}, {1'b1, c, c});
    chk($sformatf("R5 we high Q%0d", q), {we_n, wel_n, weh_n}, 3'b111);
  endtask

  // mode 0 plain, 1 = start pulse while busy (R11), 2 = inputs changed mid-access (R12)
  task automatic run_access(input logic [AW-1:0] a, input logic w, input logic [3:0] pg,
                            input logic d, input int mode);
    logic [AW-1:0] idx = a >> 1;
    logic [31:0] exp;
    req_addr = a; req_word = w; cfg_page = pg; cfg_dualcas = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (mode == 2) begin
      req_addr = ~a; req_word = ~w; cfg_page = ~pg; cfg_dualcas = ~d;
    end
    exp = {col_of(idx, pg)[15:0] ^ 16'hC35A, 16'h0000};
    for (int h = 0; h < (w ? 2 : 1); h++) begin
      for (int q = 1; q <= 5; q++) begin
        if (mode == 1 && h == 0 && q == 3) begin req_start = 1'b1; req_addr = a ^ 25'h0F0F0F; end
        if (mode == 1 && q == 4) req_start = 1'b0;
        chk_phase(q, d, idx + AW'(h), pg);
        @(negedge clk);
      end
    end
    if (w) exp[15:0] = col_of(idx + AW'(1), pg)[15:0] ^ 16'hC35A;
    chk(w ? "R7 R8 done word" : "R7 R9 done half", {done, rdata}, {1'b1, exp});
    chk("R10 busy at done", busy, 1'b0);
    req_start = 1'b0;
    @(negedge clk);
    chk("R10 done one cycle", done, 1'b0);
    if (mode == 1) chk("R11 no extra access", {busy, ras_n}, 2'b01);
    if (mode == 2) chk("R12 no access from changed inputs", {busy, ras_n}, 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk_idle_bus("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle_bus("R1 after release");
    for (int i = 0; i < NV; i++) run_access(VA[i], VW[i], VP[i], VD[i], 0);
    run_access(25'h0456780, 1'b1, 4'd3, 1'b0, 1);
    run_access(25'h0222222, 1'b0, 4'd1, 1'b1, 2);
    req_addr = 25'h0010000; req_word = 1'b1; cfg_page = 4'd0; cfg_dualcas = 1'b1; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle_bus("R1 reset mid-access");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle_bus("R1 idle after mid reset");
    run_access(25'h0000002, 1'b0, 4'd0, 1'b0, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule